// File: doc/BRIEF.md
# Legacy I/O Recovery Gap Enforcer

This block sits in front of the issue path for slow I/O cycles. It holds back the next delay-eligible I/O cycle until a minimum number of PCI clocks has passed since the previous eligible I/O cycle finished. A requester presents `req_valid` together with a two-bit target class. The block answers combinationally on `grant`. When a cycle completes, the downstream engine pulses `done_valid` and gives the class of the cycle that finished.

Two gap lengths are available, and `slow_gap` selects between them. Cycles to on-board legacy devices (DMA, interrupt controller, interval timer, RTC) are always subject to the gap. LPC I/O cycles are subject to it only while `lpc_gap_en` is set. Memory cycles are never held, and they never start a gap. The gap length is captured when a completion arrives, so changing `slow_gap` during a gap only affects the following gap.

Top module: `io_gap_guard`

## Requirements
- R1: After reset no gap is pending, and a request of any class is granted in the same cycle it is presented.
- R2: With `slow_gap` at 0 on the clock edge where an eligible `done_valid` is sampled, an eligible request is denied in each of the following 22 cycles and granted from the 23rd cycle after that edge. The 23rd cycle is the cycle that follows the 22nd later edge.
- R3: With `slow_gap` at 1 on that edge, the hold lasts 54 cycles instead.
- R4: Class code 2'b01 (legacy device) is always eligible, both for being held and for starting a gap.
- R5: Class code 2'b10 (LPC I/O) is eligible only while `lpc_gap_en` is 1. This means it is held only if the bit is 1 at request time, and it starts a gap only if the bit is 1 at completion time.
- R6: Class codes 2'b00 and 2'b11 (memory) are granted whenever requested, even during a gap, and their completion starts no gap.
- R7: A change of `slow_gap` during a running gap leaves that gap's length unchanged. The new value takes effect at the next eligible completion.
- R8: `grant` is never high while `req_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A cycle is waiting to issue |
| req_class | input | 2 | Target class of the waiting cycle (00/11 memory, 01 legacy, 10 LPC I/O) |
| done_valid | input | 1 | One-cycle strobe: a cycle has just finished |
| done_class | input | 2 | Target class of the finished cycle |
| slow_gap | input | 1 | Gap select: 0 = 22 clocks, 1 = 54 clocks |
| lpc_gap_en | input | 1 | Apply the gap to LPC I/O as well |
| grant | output | 1 | The waiting cycle may start this cycle |

## Verification
Each gap length is probed one cycle inside its boundary and exactly at its boundary, so an off-by-one in loading or expiry shows up. The same gap is then crossed with each target class and both settings of the LPC enable. This separates held traffic from passing traffic, and it separates classes that start a gap from classes that do not. Toggling the select bit in the middle of a short gap shows whether the length is captured at completion or read live.

// File: rtl/io_gap_pkg.sv
package io_gap_pkg;

  typedef enum logic [1:0] {
    CLS_MEM    = 2'b00,
    CLS_LEGACY = 2'b01,
    CLS_LPCIO  = 2'b10,
    CLS_MEM_X  = 2'b11
  } io_class_e;

  // A class is subject to the recovery gap when it is a legacy device,
  // or an LPC I/O cycle while LPC gating is enabled.
  function automatic logic class_gated(input logic [1:0] cls, input logic lpc_en);
    return (cls == CLS_LEGACY) || ((cls == CLS_LPCIO) && lpc_en);
  endfunction

  // Gap length selected by the slow bit.
  function automatic int unsigned pick_gap(input logic slow,
                                           input int unsigned short_len,
                                           input int unsigned long_len);
    return slow ? long_len : short_len;
  endfunction

endpackage

// File: rtl/io_gap_classify.sv
module io_gap_classify
  import io_gap_pkg::*;
(
  input  logic [1:0] cls,
  input  logic       lpc_en,
  output logic       gated
);
  always_comb gated = class_gated(cls, lpc_en);
endmodule

// File: rtl/io_gap_counter.sv
module io_gap_counter #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt,
  output logic          expired
);
  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/io_gap_guard.sv
module io_gap_guard
  import io_gap_pkg::*;
#(
  parameter int GAP_SHORT = 22,
  parameter int GAP_LONG  = 54
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_class,
  input  logic       done_valid,
  input  logic [1:0] done_class,
  input  logic       slow_gap,
  input  logic       lpc_gap_en,
  output logic       grant
);
  localparam int MAXG = (GAP_LONG > GAP_SHORT) ? GAP_LONG : GAP_SHORT;
  localparam int CW   = $clog2(MAXG + 1);

  logic          req_gated;
  logic          done_gated;
  logic          gap_load;
  logic          gap_idle;
  logic [CW-1:0] gap_len;
  logic [CW-1:0] cnt_q;

  io_gap_classify u_req_cls (
    .cls    (req_class),
    .lpc_en (lpc_gap_en),
    .gated  (req_gated)
  );

  io_gap_classify u_done_cls (
    .cls    (done_class),
    .lpc_en (lpc_gap_en),
    .gated  (done_gated)
  );

  assign gap_load = done_valid && done_gated;
  assign gap_len  = CW'(pick_gap(slow_gap, GAP_SHORT, GAP_LONG));

  io_gap_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (gap_load),
    .load_val (gap_len),
    .cnt      (cnt_q),
    .expired  (gap_idle)
  );

  assign grant = req_valid && (!req_gated || gap_idle);
endmodule

// File: rtl/io_gap_guard_chk.sv
module io_gap_guard_chk #(
  parameter int GAP_SHORT = 22,
  parameter int GAP_LONG  = 54,
  parameter int CW        = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [1:0]    req_class,
  input logic          done_valid,
  input logic [1:0]    done_class,
  input logic          slow_gap,
  input logic          lpc_gap_en,
  input logic          grant,
  input logic          gap_load,
  input logic [CW-1:0] cnt_q
);
  // Independent view of the remaining gap, built from the ports only.
  logic [7:0] rem;
  logic       req_elig, done_elig, req_mem;

  always_comb begin
    req_elig  = (req_class == 2'b01) || (req_class == 2'b10 && lpc_gap_en);
    done_elig = (done_class == 2'b01) || (done_class == 2'b10 && lpc_gap_en);
    req_mem   = req_class[0] == req_class[1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 rem <= '0;
    else if (done_valid && done_elig)
      rem <= slow_gap ? 8'(GAP_LONG) : 8'(GAP_SHORT);
    else if (rem != '0)         rem <= rem - 1'b1;
  end

  assert_gap_open_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rem == '0) |-> grant);

  assert_gap_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_elig && rem != '0) |-> !grant);

  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(GAP_LONG));

  assert_mem_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mem) |-> grant);

  assert_len_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gap_load |=> (cnt_q == ($past(slow_gap) ? CW'(GAP_LONG) : CW'(GAP_SHORT))));

  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !grant);
endmodule

bind io_gap_guard io_gap_guard_chk #(
  .GAP_SHORT (GAP_SHORT),
  .GAP_LONG  (GAP_LONG),
  .CW        (CW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_class  (req_class),
  .done_valid (done_valid),
  .done_class (done_class),
  .slow_gap   (slow_gap),
  .lpc_gap_en (lpc_gap_en),
  .grant      (grant),
  .gap_load   (gap_load),
  .cnt_q      (cnt_q)
);

// File: tb/io_gap_guard_test.sv
`timescale 1ns/1ps
module io_gap_guard_test;
  localparam int SHORT_G = 22;
  localparam int LONG_G  = 54;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_class = 2'b00;
  logic       done_valid = 1'b0;
  logic [1:0] done_class = 2'b00;
  logic       slow_gap = 1'b0;
  logic       lpc_gap_en = 1'b0;
  logic       grant;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  io_gap_guard #(.GAP_SHORT(SHORT_G), .GAP_LONG(LONG_G)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_class  (req_class),
    .done_valid (done_valid),
    .done_class (done_class),
    .slow_gap   (slow_gap),
    .lpc_gap_en (lpc_gap_en),
    .grant      (grant)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: grant=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Pulse a completion; returns at the negedge right after the sampling edge.
  task automatic pulse_done(input logic [1:0] cls);
    @(negedge clk);
    done_valid = 1'b1;
    done_class = cls;
    @(negedge clk);
    done_valid = 1'b0;
  endtask

  task automatic skip(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic settle();
    req_valid = 1'b0;
    skip(LONG_G + 4);
  endtask

  task automatic t_reset();
    req_valid = 1'b1;
    req_class = 2'b01;
    #1 check(grant, 1'b1, "R1 legacy granted right after reset");
    lpc_gap_en = 1'b1; req_class = 2'b10;
    #1 check(grant, 1'b1, "R1 LPC granted right after reset");
    lpc_gap_en = 1'b0;
    req_valid = 1'b0;
  endtask

  // Gap probe: 0 cycles in, last held cycle, first open cycle.
  task automatic probe_gap(input int len, input logic [1:0] cls, input string tag);
    req_valid = 1'b1;
    req_class = cls;
    #1 check(grant, 1'b0, {tag, " held at start"});
    skip(len - 1);
    #1 check(grant, 1'b0, {tag, " held last cycle"});
    skip(1);
    #1 check(grant, 1'b1, {tag, " open at boundary"});
    req_valid = 1'b0;
  endtask

  task automatic t_short_gap();
    slow_gap = 1'b0;
    pulse_done(2'b01);
    probe_gap(SHORT_G, 2'b01, "R2 R4 legacy short gap");
    settle();
  endtask

  task automatic t_long_gap();
    slow_gap = 1'b1;
    pulse_done(2'b01);
    probe_gap(LONG_G, 2'b01, "R3 legacy long gap");
    slow_gap = 1'b0;
    settle();
  endtask

  task automatic t_lpc();
    lpc_gap_en = 1'b0;
    pulse_done(2'b10);
    lpc_gap_en = 1'b1;
    req_valid = 1'b1; req_class = 2'b01;
    #1 check(grant, 1'b1, "R5 LPC done with gating off starts no gap");
    req_valid = 1'b0;
    pulse_done(2'b10);
    req_valid = 1'b1; req_class = 2'b10;
    #1 check(grant, 1'b0, "R5 LPC held when gating on");
    lpc_gap_en = 1'b0;
    #1 check(grant, 1'b1, "R5 LPC passes when gating off");
    req_class = 2'b01;
    #1 check(grant, 1'b0, "R4 legacy held whatever the LPC bit");
    req_valid = 1'b0;
    settle();
  endtask

  task automatic t_memory();
    pulse_done(2'b01);
    req_valid = 1'b1; req_class = 2'b00;
    #1 check(grant, 1'b1, "R6 memory 00 passes during gap");
    req_class = 2'b11;
    #1 check(grant, 1'b1, "R6 memory 11 passes during gap");
    req_valid = 1'b0;
    settle();
    pulse_done(2'b00);
    req_valid = 1'b1; req_class = 2'b01;
    #1 check(grant, 1'b1, "R6 memory done starts no gap");
    req_valid = 1'b0;
    pulse_done(2'b11);
    req_valid = 1'b1;
    #1 check(grant, 1'b1, "R6 memory 11 done starts no gap");
    req_valid = 1'b0;
  endtask

  task automatic t_sel_change();
    slow_gap = 1'b0;
    pulse_done(2'b01);
    skip(3);
    slow_gap = 1'b1;
    req_valid = 1'b1; req_class = 2'b01;
    skip(SHORT_G - 4);
    #1 check(grant, 1'b0, "R7 short gap still held after select change");
    skip(1);
    #1 check(grant, 1'b1, "R7 short gap kept its length");
    req_valid = 1'b0;
    pulse_done(2'b01);
    req_valid = 1'b1;
    skip(SHORT_G);
    #1 check(grant, 1'b0, "R7 new length used at next completion");
    skip(LONG_G - SHORT_G);
    #1 check(grant, 1'b1, "R7 long gap ends at its boundary");
    req_valid = 1'b0;
    slow_gap = 1'b0;
    settle();
  endtask

  task automatic t_idle();
    req_valid = 1'b0;
    for (int c = 0; c < 4; c++) begin
      req_class = c[1:0];
      #1 check(grant, 1'b0, "R8 no grant without request");
    end
    pulse_done(2'b01);
    req_class = 2'b00;
    #1 check(grant, 1'b0, "R8 no grant without request during gap");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_short_gap();
    t_long_gap();
    t_lpc();
    t_memory();
    t_sel_change();
    t_idle();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule